// File: doc/BRIEF.md
# Circular Playback Sample Feeder

This block streams audio samples out of a ring buffer in memory and hands them to a codec interface, one per codec request. It needs no processor help while it runs. The read offset wraps from the last slot back to slot zero without stopping. A programmable sample count works as a low-water mark: each time that many samples have reached the codec, a sticky wake interrupt is raised so that a sleeping processor can refill the part of the ring already played. If the codec asks for a sample before memory has returned one, the block replays the last sample it delivered and latches an underflow error.

The controller is a three-state machine:
- `PB_IDLE`: disabled. The read offset is held at zero and the wake counter is reloaded.
- `PB_FETCH`: memory request outstanding.
- `PB_READY`: one sample is held for the codec.

The named transitions are:
- start: `PB_IDLE` to `PB_FETCH` when enable is high.
- fill: `PB_FETCH` to `PB_READY` on read data valid.
- drain: `PB_READY` to `PB_FETCH` on a codec request.
- stop: any state to `PB_IDLE` when enable is low.

Top module: `ring_playback_dma`

## Requirements
- R1: When a codec request arrives in `PB_READY` with enable high, the held sample appears on `codec_data` with `codec_valid` high for exactly the next cycle, and the block returns to `PB_FETCH`.
- R2: While enabled and in `PB_FETCH`, `mem_req` is high and `mem_addr` equals `base_addr` plus the current offset. A `mem_rvalid` seen while `mem_req` is high stores `mem_rdata` as the held sample and advances the offset by one.
- R3: The offset that follows `buf_len-1` is 0, so addresses run base, base+1, …, base+buf_len-1, base, … (`buf_len` is at least 1).
- R4: `wake_irq` goes high in the cycle after the `wake_count`-th delivered sample counted since enable, and then after every further `wake_count` deliveries (`wake_count` is at least 1). Replayed underflow samples do not count.
- R5: `wake_irq` stays high until `irq_clear` is sampled high. If a new wake event and `irq_clear` fall in the same cycle, the flag stays high.
- R6: A codec request with enable high while no sample is held (`PB_IDLE` or `PB_FETCH`) gives `codec_valid` in the next cycle with `codec_data` unchanged (the last delivered sample, or 0 before any delivery). It also sets `underflow_err`, which stays high until `err_clear`. If an underflow and `err_clear` fall in the same cycle, the flag stays high.
- R7: One cycle after enable is sampled low, `mem_req` is low and codec requests produce no `codec_valid`. On the next enable, reading restarts at offset 0 and the wake count starts afresh.
- R8: During and right after reset, `mem_req`, `codec_valid`, `wake_irq` and `underflow_err` are 0 and `codec_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run control; low stops fetching and rewinds the ring |
| base_addr | input | ADDR_W | Address of ring slot 0 |
| buf_len | input | LEN_W | Number of ring slots (at least 1) |
| wake_count | input | CNT_W | Deliveries between wake interrupts (at least 1) |
| irq_clear | input | 1 | Pulse to clear `wake_irq` |
| err_clear | input | 1 | Pulse to clear `underflow_err` |
| codec_req | input | 1 | Codec asks for one sample |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_rvalid | input | 1 | Read data valid, accepted only while `mem_req` is high |
| mem_req | output | 1 | Memory read request, held until data returns |
| mem_addr | output | ADDR_W | Memory read address |
| codec_data | output | DATA_W | Sample toward the codec |
| codec_valid | output | 1 | One-cycle strobe marking `codec_data` |
| wake_irq | output | 1 | Sticky low-water wake interrupt |
| underflow_err | output | 1 | Sticky underflow error flag |

## Verification
Two pairs of events can fall in the same cycle. The first is a delivery that finishes a wake count, arriving together with an `irq_clear` pulse. The second is an underflow replay arriving together with an `err_clear` pulse. In both cases the flag must stay set. The bench forces these collisions by holding the clear inputs high across stretches of dense codec requests, once with instant memory and once with slow, random memory. A queue-free behavioural model predicts, on every clock, whether each sticky flag survives, and that prediction is compared against the ports.

// File: rtl/rpd_pkg.sv
`timescale 1ns/1ps
package rpd_pkg;
    typedef enum logic [1:0] {
        PB_IDLE  = 2'd0,
        PB_FETCH = 2'd1,
        PB_READY = 2'd2
    } pb_state_t;
endpackage

// File: rtl/rpd_ring_ptr.sv
`timescale 1ns/1ps
module rpd_ring_ptr #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic [LEN_W-1:0] buf_len,
    output logic [LEN_W-1:0] offset
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic at_end;
    assign at_end = (offset == buf_len - ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset <= '0;
        end else if (restart) begin
            offset <= '0;
        end else if (step) begin
            offset <= at_end ? '0 : offset + ONE;
        end
    end
endmodule

// File: rtl/rpd_wake_cnt.sv
`timescale 1ns/1ps
module rpd_wake_cnt #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             tick,
    input  logic [CNT_W-1:0] wake_count,
    input  logic             irq_clear,
    output logic             wake_irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] left;
    logic             fire;

    assign fire = tick && !reload && (left <= ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left <= '0;
        end else if (reload || fire) begin
            left <= wake_count;
        end else if (tick) begin
            left <= left - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_irq <= 1'b0;
        end else if (fire) begin
            wake_irq <= 1'b1;
        end else if (irq_clear) begin
            wake_irq <= 1'b0;
        end
    end
endmodule

// File: rtl/rpd_fsm.sv
`timescale 1ns/1ps
module rpd_fsm
    import rpd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              codec_req,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              err_clear,
    output logic              mem_req,
    output logic              fill,
    output logic              drain,
    output logic              rewind,
    output logic [DATA_W-1:0] codec_data,
    output logic              codec_valid,
    output logic              underflow_err
);
    pb_state_t         state, state_nx;
    logic              starve;
    logic [DATA_W-1:0] hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PB_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = PB_IDLE;
        end else begin
            unique case (state)
                PB_IDLE:  state_nx = PB_FETCH;
                PB_FETCH: if (mem_rvalid) state_nx = PB_READY;
                PB_READY: if (codec_req)  state_nx = PB_FETCH;
                default:  state_nx = PB_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req = 1'b0;
        fill    = 1'b0;
        drain   = 1'b0;
        starve  = 1'b0;
        rewind  = !enable;
        if (enable) begin
            unique case (state)
                PB_IDLE: begin
                    starve = codec_req;
                end
                PB_FETCH: begin
                    mem_req = 1'b1;
                    fill    = mem_rvalid;
                    starve  = codec_req;
                end
                PB_READY: begin
                    drain = codec_req;
                end
                default: begin
                    starve = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold        <= '0;
            codec_data  <= '0;
            codec_valid <= 1'b0;
        end else begin
            codec_valid <= drain || starve;
            if (fill) begin
                hold <= mem_rdata;
            end
            if (drain) begin
                codec_data <= hold;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            underflow_err <= 1'b0;
        end else if (starve) begin
            underflow_err <= 1'b1;
        end else if (err_clear) begin
            underflow_err <= 1'b0;
        end
    end
endmodule

// File: rtl/ring_playback_dma.sv
`timescale 1ns/1ps
module ring_playback_dma #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 12,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  buf_len,
    input  logic [CNT_W-1:0]  wake_count,
    input  logic              irq_clear,
    input  logic              err_clear,
    input  logic              codec_req,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] codec_data,
    output logic              codec_valid,
    output logic              wake_irq,
    output logic              underflow_err
);
    logic             fill, drain, rewind;
    logic [LEN_W-1:0] offset;

    rpd_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .codec_req     (codec_req),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .err_clear     (err_clear),
        .mem_req       (mem_req),
        .fill          (fill),
        .drain         (drain),
        .rewind        (rewind),
        .codec_data    (codec_data),
        .codec_valid   (codec_valid),
        .underflow_err (underflow_err)
    );

    rpd_ring_ptr #(.LEN_W(LEN_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (rewind),
        .step    (fill),
        .buf_len (buf_len),
        .offset  (offset)
    );

    rpd_wake_cnt #(.CNT_W(CNT_W)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (rewind),
        .tick       (drain),
        .wake_count (wake_count),
        .irq_clear  (irq_clear),
        .wake_irq   (wake_irq)
    );

    assign mem_addr = base_addr + ADDR_W'(offset);
endmodule

// File: rtl/rpd_checker.sv
`timescale 1ns/1ps
module rpd_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [ADDR_W-1:0] base_addr,
    input logic              codec_req,
    input logic              mem_req,
    input logic              mem_rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              codec_valid,
    input logic              wake_irq,
    input logic              irq_clear,
    input logic              underflow_err,
    input logic              err_clear
);
    AST_REQ_STOPS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !mem_req); // R7
    AST_VALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        codec_valid |-> $past(codec_req && enable)); // R1
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid && enable) |=>
            (mem_addr == $past(mem_addr)) || (base_addr != $past(base_addr))); // R2
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_irq && !irq_clear) |=> wake_irq); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_err && !err_clear) |=> underflow_err); // R6
    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow_err) |-> $past(codec_req)); // R6
endmodule

bind ring_playback_dma rpd_checker #(.ADDR_W(ADDR_W)) u_rpd_checker (.*);

// File: tb/ring_playback_dma_bench.sv
`timescale 1ns/1ps
module ring_playback_dma_bench;
    localparam int AW = 16, DW = 16, LW = 12, CW = 12;

    logic          clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [LW-1:0] buf_len = LW'(1);
    logic [CW-1:0] wake_count = CW'(1);
    logic          irq_clear = 1'b0, err_clear = 1'b0, codec_req = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_rvalid = 1'b0;
    logic          mem_req, codec_valid, wake_irq, underflow_err;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] codec_data;

    ring_playback_dma #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .CNT_W(CW)) u_ring_playback_dma (
        .clk(clk), .rst_n(rst_n), .enable(enable), .base_addr(base_addr),
        .buf_len(buf_len), .wake_count(wake_count), .irq_clear(irq_clear),
        .err_clear(err_clear), .codec_req(codec_req), .mem_rdata(mem_rdata),
        .mem_rvalid(mem_rvalid), .mem_req(mem_req), .mem_addr(mem_addr),
        .codec_data(codec_data), .codec_valid(codec_valid), .wake_irq(wake_irq),
        .underflow_err(underflow_err));

    always #10 clk = ~clk;

    int tests = 0, fails = 0;
    bit done = 0;

    // behavioural reference: 0 idle, 1 waiting for memory, 2 sample held
    int st = 0, idx = 0, left = 0, hold = 0, m_data = 0;
    bit m_valid = 0, m_irq = 0, m_err = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st = 0; idx = 0; left = 0; hold = 0; m_data = 0;
            m_valid = 0; m_irq = 0; m_err = 0;
        end else begin
            bit dr, sv, fl, wake;
            dr = enable && st == 2 && codec_req;
            sv = enable && st != 2 && codec_req;
            fl = enable && st == 1 && mem_rvalid;
            wake = 0;
            m_valid = dr || sv;
            if (dr) m_data = hold;
            if (fl) hold = int'(mem_rdata);
            if (sv) m_err = 1; else if (err_clear) m_err = 0;
            if (!enable) left = int'(wake_count);
            else if (dr) begin
                if (left <= 1) begin left = int'(wake_count); wake = 1; end
                else left = left - 1;
            end
            if (wake) m_irq = 1; else if (irq_clear) m_irq = 0;
            if (!enable) idx = 0;
            else if (fl) idx = (idx + 1 >= int'(buf_len)) ? 0 : idx + 1;
            if (!enable) st = 0;
            else if (st == 0) st = 1;
            else if (st == 1 && mem_rvalid) st = 2;
            else if (st == 2 && codec_req) st = 1;
        end
    end

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R2/R7 mem_req", int'(mem_req), int'(st == 1));
        if (st == 1) check("R2/R3 mem_addr", int'(mem_addr), (int'(base_addr) + idx) & 16'hFFFF);
        check("R1/R6/R7 codec_valid", int'(codec_valid), int'(m_valid));
        if (m_valid) check("R1/R6 codec_data", int'(codec_data), m_data);
        check("R4/R5 wake_irq", int'(wake_irq), int'(m_irq));
        check("R6 underflow_err", int'(underflow_err), int'(m_err));
    endtask

    // mem_mode: 0 answers at once, 1 answers at random, 2 never answers
    int mem_mode = 0;
    int creq_pct = 30, iclr_pct = 0, eclr_pct = 0;

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            codec_req  = ($urandom % 100) < creq_pct;
            irq_clear  = ($urandom % 100) < iclr_pct;
            err_clear  = ($urandom % 100) < eclr_pct;
            mem_rvalid = mem_req && (mem_mode == 0 || (mem_mode == 1 && ($urandom % 3) == 0));
            mem_rdata  = DW'(mem_addr * 5 + 3);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset values
        check("R8 mem_req", int'(mem_req), 0);
        check("R8 codec_valid", int'(codec_valid), 0);
        check("R8 codec_data", int'(codec_data), 0);
        check("R8 wake_irq", int'(wake_irq), 0);
        check("R8 underflow_err", int'(underflow_err), 0);
        rst_n = 1'b1;
        run(3);
        // R1 R2 R3 R4: fast memory, ring of 5, wake every 3
        base_addr = 16'h0100; buf_len = LW'(5); wake_count = CW'(3);
        enable = 1'b1; creq_pct = 30; mem_mode = 0;
        run(120);
        // R5 R6: collisions of set and clear, slow memory and dense requests
        mem_mode = 1; creq_pct = 70; iclr_pct = 60; eclr_pct = 60;
        run(200);
        mem_mode = 0; creq_pct = 90; iclr_pct = 100; eclr_pct = 0;
        run(80);
        // R6: memory silent, requests replay the last sample
        mem_mode = 2; creq_pct = 50; iclr_pct = 0;
        run(30);
        // R7: disable drops request and ignores codec
        enable = 1'b0; mem_mode = 0;
        run(20);
        // R3 R4 R7: restart at slot 0, single-slot ring, wake every delivery
        base_addr = 16'hFFFE; buf_len = LW'(1); wake_count = CW'(1);
        enable = 1'b1; iclr_pct = 40; eclr_pct = 40; creq_pct = 40;
        run(150);
        // ring of 2 near the address top, long wake interval
        enable = 1'b0; run(2);
        base_addr = 16'hFFFF; buf_len = LW'(2); wake_count = CW'(7); enable = 1'b1;
        mem_mode = 1; iclr_pct = 10; eclr_pct = 20;
        run(300);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule